// File: doc/BRIEF.md
# Two-Wire Command Receiver for a Dual 8-Bit DAC

This block is the serial front end of a two-channel 8-bit DAC. It runs on a system clock and oversamples the two-wire bus lines, SCL and SDA. That clock must run at least eight times faster than SCL. The block finds START, repeated START and STOP conditions and checks the device address bit by bit as it arrives. It then receives write frames of two bytes each. Each frame carries a 4-bit command, eight bits of DAC data and four sub-bits that must be zero.

Every channel has an input register and a DAC register. These registers change in one place only: on the SCL falling edge that ends the acknowledge bit of a complete, valid frame. If a frame is broken off by a STOP or a START, the block drops it. If the address does not match, the block stays silent until the next START. One escape code sets an extended-mode flag in place of loading data.

The outputs are the four register values, the extended-mode flag and an enable that pulls SDA low. The pad logic turns that enable into the open-drain acknowledge.

Top module: `i2c_dac_cmd_rx`

## Requirements
- R1: Both bus lines pass through a synchronizer of SYNC_STAGES flops. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START seen anywhere, including inside a frame, restarts address reception.
- R2: The block acknowledges by holding `sda_pull` high from the SCL fall after the eighth bit of a byte until the SCL fall after the ninth clock. It does this for a matching address byte, for every command byte and for every data byte. `sda_pull` never changes while SCL is high.
- R3: The device address is {ADDR_HI, addr_strap}, which is 0111_00x by default. It is sent MSB first, and the byte's LSB is the read/write flag, where 0 means write.
- R4: At the first address bit that does not match, the block stops taking part. It acknowledges nothing and changes no register until the next START.
- R5: A read request (flag 1) with a matching address is acknowledged. After that the block releases SDA and acknowledges nothing more until the next START.
- R6: The registers change only on the SCL falling edge that ends the acknowledge of the second byte of a frame. They hold their old values while that ninth clock is high.
- R7: The first frame byte is {cmd[3:0], data[7:4]} and the second is {data[3:0], sub[3:0]}. A frame whose sub-bits are not all zero is acknowledged but changes nothing.
- R8: A frame cut short changes nothing. This covers a STOP after the first byte, a STOP in the middle of a byte, and a repeated START.
- R9: The commands are as follows. 0000 loads input A. 0001 loads input B. 0010 loads input A and copies both inputs into the DAC registers. 0011 loads input B and copies both. 1000 copies both inputs into the DAC registers and loads nothing.
- R10: Command 1111 with data[7:4] = 0000 sets `ext_mode` and leaves all data registers alone. A later frame with an R9 command clears the flag. Any other code is acknowledged and changes nothing.
- R11: After a completed frame, more frames may follow in the same transfer without a new address byte.
- R12: After reset all data registers are 0, `ext_mode` is 0 and `sda_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Sets the lowest device address bit |
| sda_pull | output | 1 | High to pull SDA low (acknowledge) |
| in_a | output | 8 | Channel A input register |
| in_b | output | 8 | Channel B input register |
| dac_a | output | 8 | Channel A DAC register |
| dac_b | output | 8 | Channel B DAC register |
| ext_mode | output | 1 | Extended command mode flag |

## Verification
A wrong bit counter or frame state shows up first on `sda_pull`. The acknowledge then appears on the wrong clock or is missing, and the bench sees this in the ninth clock of the byte in question. A state that commits too early shows up as a register that has already changed while the final acknowledge clock is still high. A state that ignores an abort or a mismatch shows up as a register changed after the STOP. The bench checks all three at those points, and after every frame it compares the five held outputs with a model of the frame rules.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;
   localparam int DAC_W   = 8;
   localparam int CMD_W   = 4;
   localparam int CH_N    = 2;

   localparam logic [CMD_W-1:0] CMD_LD_A    = 4'b0000;
   localparam logic [CMD_W-1:0] CMD_LD_B    = 4'b0001;
   localparam logic [CMD_W-1:0] CMD_LD_A_UP = 4'b0010;
   localparam logic [CMD_W-1:0] CMD_LD_B_UP = 4'b0011;
   localparam logic [CMD_W-1:0] CMD_UPDATE  = 4'b1000;
   localparam logic [CMD_W-1:0] CMD_ESCAPE  = 4'b1111;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_DAT, ST_DAT_ACK, ST_SKIP
   } rx_state_t;

   typedef struct packed {
      logic [CMD_W-1:0] cmd;
      logic [DAC_W-1:0] data;
   } frame_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_s,
   output logic start_det,
   output logic stop_det
);
   localparam int LINES = 2;

   logic [LINES-1:0] raw;
   logic [LINES-1:0] line_s;
   logic [LINES-1:0] line_p;

   assign raw = {scl_in, sda_in};

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[l]};
      end
      assign line_s[l] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_p <= '1;
      else        line_p <= line_s;
   end

   assign scl_s     = line_s[1];
   assign sda_s     = line_s[0];
   assign scl_rise  =  line_s[1] & ~line_p[1];
   assign scl_fall  = ~line_s[1] &  line_p[1];
   assign start_det =  line_s[1] & line_p[1] &  line_p[0] & ~line_s[0];
   assign stop_det  =  line_s[1] & line_p[1] & ~line_p[0] &  line_s[0];
endmodule

// File: rtl/i2c_frame_fsm.sv
module i2c_frame_fsm
   import dac_i2c_pkg::*;
#(
   parameter logic [5:0] ADDR_HI = 6'b011100
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sda_s,
   input  logic   scl_rise,
   input  logic   scl_fall,
   input  logic   start_det,
   input  logic   stop_det,
   input  logic   addr_lsb,
   output logic   sda_pull,
   output logic   commit,
   output frame_t frame
);
   localparam int BYTE_W = 8;
   localparam int BIT_W  = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
   localparam logic [BIT_W-1:0] TOP_ADDR = BIT_W'(BYTE_W - 2);

   rx_state_t          state_q;
   logic [BIT_W-1:0]   bit_q;
   logic [BYTE_W-1:0]  shift_q;
   logic [BYTE_W-1:0]  cmd_q;
   logic               byte_done_q;
   logic               ack_high_q;
   logic [BYTE_W-2:0]  own_addr;
   logic               rx_phase;
   logic               ack_phase;
   logic               ack_end;
   logic               addr_bad;

   assign own_addr  = {ADDR_HI, addr_lsb};
   assign rx_phase  = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_DAT);
   assign ack_phase = (state_q == ST_ADDR_ACK) || (state_q == ST_CMD_ACK) || (state_q == ST_DAT_ACK);
   assign ack_end   = ack_phase & ack_high_q & scl_fall;
   assign addr_bad  = (state_q == ST_ADDR) && scl_rise && !byte_done_q &&
                      (bit_q != LAST_BIT) && (sda_s != own_addr[TOP_ADDR - bit_q]);

   assign commit     = ack_end && (state_q == ST_DAT_ACK) && (shift_q[3:0] == 4'b0000);
   assign frame.cmd  = cmd_q[7:4];
   assign frame.data = {cmd_q[3:0], shift_q[7:4]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         bit_q       <= '0;
         shift_q     <= '0;
         cmd_q       <= '0;
         byte_done_q <= 1'b0;
         ack_high_q  <= 1'b0;
         sda_pull    <= 1'b0;
      end else if (start_det) begin
         state_q     <= ST_ADDR;
         bit_q       <= '0;
         byte_done_q <= 1'b0;
         ack_high_q  <= 1'b0;
         sda_pull    <= 1'b0;
      end else if (stop_det) begin
         state_q     <= ST_IDLE;
         bit_q       <= '0;
         byte_done_q <= 1'b0;
         ack_high_q  <= 1'b0;
         sda_pull    <= 1'b0;
      end else begin
         if (rx_phase && scl_rise && !byte_done_q) begin
            shift_q <= {shift_q[BYTE_W-2:0], sda_s};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) byte_done_q <= 1'b1;
            if (addr_bad)          state_q     <= ST_SKIP;
         end
         if (rx_phase && scl_fall && byte_done_q) begin
            byte_done_q <= 1'b0;
            sda_pull    <= 1'b1;
            case (state_q)
               ST_ADDR: state_q <= ST_ADDR_ACK;
               ST_CMD:  state_q <= ST_CMD_ACK;
               default: state_q <= ST_DAT_ACK;
            endcase
         end
         if (ack_phase && scl_rise) ack_high_q <= 1'b1;
         if (ack_end) begin
            ack_high_q <= 1'b0;
            sda_pull   <= 1'b0;
            bit_q      <= '0;
            case (state_q)
               ST_ADDR_ACK: state_q <= shift_q[0] ? ST_SKIP : ST_CMD;
               ST_CMD_ACK: begin
                  cmd_q   <= shift_q;
                  state_q <= ST_DAT;
               end
               default:     state_q <= ST_CMD;
            endcase
         end
      end
   end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
   import dac_i2c_pkg::*;
(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       commit,
   input  frame_t                     frame,
   output logic [CH_N-1:0][DAC_W-1:0] in_regs,
   output logic [CH_N-1:0][DAC_W-1:0] dac_regs,
   output logic                       ext_mode
);
   logic xfer;
   logic known;
   logic escape;

   assign xfer   = commit && ((frame.cmd == CMD_LD_A_UP) || (frame.cmd == CMD_LD_B_UP) ||
                              (frame.cmd == CMD_UPDATE));
   assign known  = commit && ((frame.cmd[3:2] == 2'b00) || (frame.cmd == CMD_UPDATE));
   assign escape = commit && (frame.cmd == CMD_ESCAPE) && (frame.data[7:4] == 4'b0000);

   for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
      logic             load;
      logic [DAC_W-1:0] in_r;
      logic [DAC_W-1:0] dac_r;
      logic [DAC_W-1:0] next_in;

      assign load    = commit && (frame.cmd[3:2] == 2'b00) && (frame.cmd[0] == 1'(ch));
      assign next_in = load ? frame.data : in_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_r  <= '0;
            dac_r <= '0;
         end else begin
            if (load) in_r  <= frame.data;
            if (xfer) dac_r <= next_in;
         end
      end
      assign in_regs[ch]  = in_r;
      assign dac_regs[ch] = dac_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ext_mode <= 1'b0;
      else if (escape) ext_mode <= 1'b1;
      else if (known)  ext_mode <= 1'b0;
   end
endmodule

// File: rtl/i2c_dac_cmd_rx.sv
module i2c_dac_cmd_rx
   import dac_i2c_pkg::*;
#(
   parameter logic [5:0] ADDR_HI     = 6'b011100,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic             addr_strap,
   output logic             sda_pull,
   output logic [DAC_W-1:0] in_a,
   output logic [DAC_W-1:0] in_b,
   output logic [DAC_W-1:0] dac_a,
   output logic [DAC_W-1:0] dac_b,
   output logic             ext_mode
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CH_N != 2) begin : g_bad_ch
      $error("the frame format addresses exactly two channels");
   end

   logic   scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic   commit;
   frame_t frame;
   logic [CH_N-1:0][DAC_W-1:0] in_regs, dac_regs;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_frame_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .addr_lsb(addr_strap),
      .sda_pull(sda_pull), .commit(commit), .frame(frame)
   );

   dac_reg_bank u_bank (
      .clk(clk), .rst_n(rst_n), .commit(commit), .frame(frame),
      .in_regs(in_regs), .dac_regs(dac_regs), .ext_mode(ext_mode)
   );

   assign in_a  = in_regs[0];
   assign in_b  = in_regs[1];
   assign dac_a = dac_regs[0];
   assign dac_b = dac_regs[1];
endmodule

// File: rtl/dac_i2c_checker.sv
module dac_i2c_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       scl_fall,
   input logic       stop_det,
   input logic       sda_pull,
   input logic [7:0] in_a,
   input logic [7:0] in_b,
   input logic [7:0] dac_a,
   input logic [7:0] dac_b,
   input logic       ext_mode
);
   // R6: register updates follow an SCL falling edge
   assert_commit_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(in_a) || !$stable(in_b) || !$stable(dac_a) || !$stable(dac_b)) |-> $past(scl_fall));

   // R2: the acknowledge drive never moves while SCL stays high
   assert_pull_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_pull));

   // R8: a STOP leaves the data line released
   assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_det) |-> !sda_pull);

   // R10: entering extended mode loads no data
   assert_escape_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_mode) |-> ($stable(in_a) && $stable(in_b) && $stable(dac_a) && $stable(dac_b)));
endmodule

bind i2c_dac_cmd_rx dac_i2c_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall), .stop_det(stop_det),
   .sda_pull(sda_pull), .in_a(in_a), .in_b(in_b), .dac_a(dac_a), .dac_b(dac_b),
   .ext_mode(ext_mode)
);

// File: tb/sim_i2c_dac_cmd_rx.sv
module sim_i2c_dac_cmd_rx;
   localparam int HP = 10;
   localparam logic [6:0] BASE = 7'b0111000;

   logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
   logic sda_pull, ext_mode, sda_bus;
   logic [7:0] in_a, in_b, dac_a, dac_b;
   logic [7:0] ea = '0, eb = '0, eda = '0, edb = '0;
   logic eext = 1'b0;
   int n_run = 0, n_fail = 0;

   assign sda_bus = m_sda & ~sda_pull;
   always #10 clk = ~clk;

   i2c_dac_cmd_rx u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .addr_strap(strap),
      .sda_pull(sda_pull), .in_a(in_a), .in_b(in_b), .dac_a(dac_a), .dac_b(dac_b),
      .ext_mode(ext_mode)
   );

   task automatic tk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      chk(req, "in_a", in_a, ea);
      chk(req, "in_b", in_b, eb);
      chk(req, "dac_a", dac_a, eda);
      chk(req, "dac_b", dac_b, edb);
      chk(req, "ext_mode", ext_mode, eext);
   endtask

   task automatic model(input logic [3:0] cmd, input logic [7:0] data, input logic [3:0] sub);
      if (sub != 4'h0) return;
      case (cmd)
         4'b0000: begin ea = data; eext = 1'b0; end
         4'b0001: begin eb = data; eext = 1'b0; end
         4'b0010: begin ea = data; eda = ea; edb = eb; eext = 1'b0; end
         4'b0011: begin eb = data; eda = ea; edb = eb; eext = 1'b0; end
         4'b1000: begin eda = ea; edb = eb; eext = 1'b0; end
         4'b1111: if (data[7:4] == 4'h0) eext = 1'b1;
         default: ;
      endcase
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; tk(HP); m_scl = 1'b1; tk(HP); m_sda = 1'b0; tk(HP); m_scl = 1'b0; tk(HP);
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; tk(HP); m_scl = 1'b1; tk(HP); m_sda = 1'b1; tk(HP);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; tk(HP); m_scl = 1'b1; tk(HP); m_scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input bit hold_chk, input string req,
                            output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      m_sda = 1'b1; tk(HP); m_scl = 1'b1; tk(HP / 2);
      ack = ~sda_bus;
      if (hold_chk) check_regs(req);
      tk(HP / 2); m_scl = 1'b0; tk(2);
   endtask

   task automatic write_frame(input logic [6:0] addr, input logic [3:0] cmd,
                              input logic [7:0] data, input logic [3:0] sub,
                              input bit exp_ack, input string req);
      bit a;
      i2c_start();
      send_byte({addr, 1'b0}, 1'b0, req, a); chk(req, "address ack", a, exp_ack);
      send_byte({cmd, data[7:4]}, 1'b0, req, a); chk(req, "command ack", a, exp_ack);
      send_byte({data[3:0], sub}, exp_ack, req, a); chk(req, "data ack", a, exp_ack);
      i2c_stop();
      if (exp_ack) model(cmd, data, sub);
      check_regs(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      bit a;
      void'($urandom(32'h5EED_1234));
      tk(5); rst_n = 1'b1; tk(5);
      // R12: reset state
      check_regs("R12");
      chk("R12", "sda_pull", sda_pull, 0);

      // R9 R3: load channel A, then load B with transfer
      write_frame(BASE, 4'b0000, 8'h5A, 4'h0, 1'b1, "R9");
      write_frame(BASE, 4'b0011, 8'hC3, 4'h0, 1'b1, "R9");
      write_frame(BASE, 4'b0001, 8'h17, 4'h0, 1'b1, "R6");
      write_frame(BASE, 4'b1000, 8'h00, 4'h0, 1'b1, "R9");
      write_frame(BASE, 4'b0010, 8'hE8, 4'h0, 1'b1, "R9");

      // R4: wrong upper address bits, nothing acked or changed
      write_frame(7'b1011000, 4'b0000, 8'h99, 4'h0, 1'b0, "R4");

      // R3: strap sets A0
      strap = 1'b1;
      write_frame(BASE, 4'b0001, 8'h42, 4'h0, 1'b0, "R3");
      write_frame(BASE | 7'd1, 4'b0001, 8'h42, 4'h0, 1'b1, "R3");
      strap = 1'b0;

      // R7: nonzero sub-bits acked, no change
      write_frame(BASE, 4'b0000, 8'h11, 4'hA, 1'b1, "R7");

      // R8: STOP after the first frame byte
      i2c_start();
      send_byte({BASE, 1'b0}, 1'b0, "R8", a);
      send_byte({4'b0000, 4'h7}, 1'b0, "R8", a);
      i2c_stop();
      check_regs("R8");

      // R8: illegal STOP in the middle of the second byte
      i2c_start();
      send_byte({BASE, 1'b0}, 1'b0, "R8", a);
      send_byte({4'b0010, 4'h3}, 1'b0, "R8", a);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      i2c_stop();
      check_regs("R8");

      // R1 R8: repeated START discards the partial frame, the next one commits
      i2c_start();
      send_byte({BASE, 1'b0}, 1'b0, "R1", a);
      send_byte({4'b0001, 4'hF}, 1'b0, "R1", a);
      i2c_start();
      send_byte({BASE, 1'b0}, 1'b0, "R1", a); chk("R1", "address ack after restart", a, 1);
      send_byte({4'b0001, 4'h6}, 1'b0, "R1", a);
      send_byte({4'h9, 4'h0}, 1'b1, "R1", a);
      i2c_stop();
      model(4'b0001, 8'h69, 4'h0);
      check_regs("R1");

      // R5: read request acked, then silence
      i2c_start();
      send_byte({BASE, 1'b1}, 1'b0, "R5", a); chk("R5", "read address ack", a, 1);
      send_byte(8'hFF, 1'b0, "R5", a); chk("R5", "no ack after read", a, 0);
      send_byte(8'h00, 1'b0, "R5", a); chk("R5", "no ack after read", a, 0);
      i2c_stop();
      check_regs("R5");

      // R10: escape, unknown code, then a load clears the flag
      write_frame(BASE, 4'b1111, 8'h05, 4'h0, 1'b1, "R10");
      write_frame(BASE, 4'b0101, 8'hAB, 4'h0, 1'b1, "R10");
      write_frame(BASE, 4'b1111, 8'h30, 4'h0, 1'b1, "R10");
      write_frame(BASE, 4'b0000, 8'h3C, 4'h0, 1'b1, "R10");

      // R11: two frames in one transfer
      i2c_start();
      send_byte({BASE, 1'b0}, 1'b0, "R11", a);
      send_byte({4'b0000, 4'hD}, 1'b0, "R11", a);
      send_byte({4'h2, 4'h0}, 1'b1, "R11", a);
      model(4'b0000, 8'hD2, 4'h0);
      send_byte({4'b0011, 4'h4}, 1'b0, "R11", a); chk("R11", "second command ack", a, 1);
      send_byte({4'hB, 4'h0}, 1'b1, "R11", a); chk("R11", "second data ack", a, 1);
      i2c_stop();
      model(4'b0011, 8'h4B, 4'h0);
      check_regs("R11");

      // random frames
      for (int i = 0; i < 40; i++) begin
         logic [3:0] cmd;
         logic [7:0] data;
         logic [3:0] sub;
         int sel;
         sel  = int'($urandom % 8);
         data = 8'($urandom);
         case (sel)
            0: cmd = 4'b0000;
            1: cmd = 4'b0001;
            2: cmd = 4'b0010;
            3: cmd = 4'b0011;
            4: cmd = 4'b1000;
            5: begin cmd = 4'b1111; data[7:4] = 4'h0; end
            default: cmd = 4'($urandom);
         endcase
         sub = (($urandom % 5) == 0) ? 4'($urandom % 15 + 1) : 4'h0;
         write_frame(BASE, cmd, data, sub, 1'b1, "R9");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule